// File: doc/BRIEF.md
# Repeat-Masked Calendar Alarm

This block is a secondary alarm comparator that sits beside a calendar timekeeping counter. Software programs a target second, minute, hour, date and month into five byte registers. On each one-second tick the block compares the running time against those targets. When they agree and the alarm is switched on, a sticky flag is set. The flag can drive an interrupt line.

The top bit of each target byte is a repeat bit. The five repeat bits together decide which fields take part in the match, so the alarm can fire every second, minute, hour, day or month, or once a year. When the alarm is switched off, the same five bytes serve as general-purpose storage. Software clears the flag by reading the flag register.

The interrupt is held off while the system runs on backup power, unless a separate backup enable is set.

Top module: `cal_repeat_alarm`

## Requirements
- R1: After a synchronous reset the following are all 0: the control register, all five target bytes, the flag and `irq`. A read of any address returns 0.
- R2: With the enable bit (control bit 0) clear, the target bytes at addresses 1 to 5 read back all 8 written bits, and no time value ever sets the flag.
- R3: With the enable bit set, a tick on which the time matches sets the flag at that clock edge. The flag stays set until it is cleared.
- R4: A match is evaluated only on cycles with `sec_tick` high. A matching time without a tick leaves the flag unchanged.
- R5: Address 1 holds the seconds target, 2 minutes, 3 hours, 4 date and 5 month. Bits 6:0 of each byte are the compare value and bit 7 is that field's repeat bit. Reading the repeat bits from month down to seconds: 11111 matches every second, 11110 compares seconds, 11100 adds minutes, 11000 adds hours, 10000 adds date, and 00000 compares all five fields.
- R6: A repeat code outside the six listed acts as the listed code that masks every field from its lowest set repeat bit upward. For example, 10100 acts as 11100.
- R7: A read of address 6 returns the flag in bit 0 one cycle after `rd_en`, and clears the flag at that edge.
- R8: If a flag-register read and a tick with a match fall on the same edge, the flag stays set.
- R9: `irq` is high exactly when the flag is set, the interrupt enable (control bit 1) is set, and either `on_backup` is low or the backup enable (control bit 2) is set. It follows the flag at the same edge.
- R10: Writes take effect at the clock edge. A read of address 0 returns the control bits in bits 2:0, and address 7 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data, valid the cycle after `rd_en` |
| cur_time | input | 35 | Running time, 7 bits per field, seconds at bits 6:0 up to month at bits 34:28 |
| sec_tick | input | 1 | One-cycle pulse once per second |
| on_backup | input | 1 | High while running on backup power |
| irq | output | 1 | Alarm interrupt, active high |

## Verification
A wrong mask prefix in the comparator shows up on the first tick after the repeat bits are written. The flag and `irq` then either fail to rise or rise on a time that differs in a field that should have been compared. A flag register that mishandles clearing is visible at the next flag read, one cycle after the strobe, and on `irq` at the same edge. Corrupted storage bytes appear on the first read-back.

// File: rtl/cra_pkg.sv
package cra_pkg;
  localparam int FIELD_W_DEF    = 7;
  localparam int NUM_FIELDS_DEF = 5;
  localparam int CTRL_EN_BIT    = 0;
  localparam int CTRL_IRQ_BIT   = 1;
  localparam int CTRL_BKUP_BIT  = 2;
  localparam int CTRL_W         = 3;
endpackage

// File: rtl/cra_regs.sv
module cra_regs #(
  parameter int FIELD_W    = cra_pkg::FIELD_W_DEF,
  parameter int NUM_FIELDS = cra_pkg::NUM_FIELDS_DEF,
  parameter int ADDR_W     = $clog2(NUM_FIELDS + 2),
  localparam int BYTE_W    = FIELD_W + 1
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 wr_en,
  input  logic                                 rd_en,
  input  logic [ADDR_W-1:0]                    addr,
  input  logic [BYTE_W-1:0]                    wdata,
  input  logic                                 flag,
  output logic [cra_pkg::CTRL_W-1:0]           ctrl,
  output logic [NUM_FIELDS-1:0][FIELD_W-1:0]   tgt_val,
  output logic [NUM_FIELDS-1:0]                rpt,
  output logic [BYTE_W-1:0]                    rdata
);
  localparam logic [ADDR_W-1:0] ADDR_CTRL  = '0;
  localparam logic [ADDR_W-1:0] ADDR_FLAGS = ADDR_W'(NUM_FIELDS + 1);

  logic [NUM_FIELDS-1:0][BYTE_W-1:0] bytes_all;

  always_ff @(posedge clk) begin
    if (rst) ctrl <= '0;
    else if (wr_en && addr == ADDR_CTRL) ctrl <= wdata[cra_pkg::CTRL_W-1:0];
  end

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_byte
    logic [BYTE_W-1:0] byte_q;
    always_ff @(posedge clk) begin
      if (rst) byte_q <= '0;
      else if (wr_en && addr == ADDR_W'(g + 1)) byte_q <= wdata;
    end
    assign bytes_all[g] = byte_q;
    assign tgt_val[g]   = byte_q[FIELD_W-1:0];
    assign rpt[g]       = byte_q[BYTE_W-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= '0;
      if (addr == ADDR_CTRL) rdata <= BYTE_W'(ctrl);
      if (addr == ADDR_FLAGS) rdata <= BYTE_W'(flag);
      for (int i = 0; i < NUM_FIELDS; i++) begin
        if (addr == ADDR_W'(i + 1)) rdata <= bytes_all[i];
      end
    end
  end
endmodule

// File: rtl/cra_match.sv
module cra_match #(
  parameter int FIELD_W    = cra_pkg::FIELD_W_DEF,
  parameter int NUM_FIELDS = cra_pkg::NUM_FIELDS_DEF
) (
  input  logic [NUM_FIELDS-1:0][FIELD_W-1:0] tgt_val,
  input  logic [NUM_FIELDS-1:0]              rpt,
  input  logic [NUM_FIELDS*FIELD_W-1:0]      cur_time,
  output logic                               hit
);
  logic [NUM_FIELDS-1:0] masked;
  logic [NUM_FIELDS-1:0] agree;

  // A field is ignored when its own repeat bit or any lower one is set,
  // which rounds odd codes toward the listed code with fewer compares.
  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_cmp
    if (g == 0) begin : g_first
      assign masked[g] = rpt[g];
    end else begin : g_rest
      assign masked[g] = rpt[g] | masked[g-1];
    end
    assign agree[g] = masked[g] || (cur_time[g*FIELD_W +: FIELD_W] == tgt_val[g]);
  end

  assign hit = &agree;
endmodule

// File: rtl/cra_flag.sv
module cra_flag (
  input  logic clk,
  input  logic rst,
  input  logic sec_tick,
  input  logic alarm_en,
  input  logic hit,
  input  logic clr_req,
  input  logic irq_en,
  input  logic bkup_en,
  input  logic on_backup,
  output logic flag,
  output logic irq
);
  logic set_now;
  logic flag_n;

  assign set_now = sec_tick && alarm_en && hit;
  assign flag_n  = set_now || (flag && !clr_req);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
      irq  <= 1'b0;
    end else begin
      flag <= flag_n;
      irq  <= flag_n && irq_en && (!on_backup || bkup_en);
    end
  end
endmodule

// File: rtl/cal_repeat_alarm.sv
module cal_repeat_alarm #(
  parameter int FIELD_W    = cra_pkg::FIELD_W_DEF,
  parameter int NUM_FIELDS = cra_pkg::NUM_FIELDS_DEF,
  localparam int ADDR_W    = $clog2(NUM_FIELDS + 2),
  localparam int BYTE_W    = FIELD_W + 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic                          rd_en,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [BYTE_W-1:0]             wdata,
  output logic [BYTE_W-1:0]             rdata,
  input  logic [NUM_FIELDS*FIELD_W-1:0] cur_time,
  input  logic                          sec_tick,
  input  logic                          on_backup,
  output logic                          irq
);
  logic [cra_pkg::CTRL_W-1:0]          ctrl;
  logic [NUM_FIELDS-1:0][FIELD_W-1:0]  tgt_val;
  logic [NUM_FIELDS-1:0]               rpt;
  logic                                hit;
  logic                                alarm_flag;
  logic                                clr_req;

  assign clr_req = rd_en && (addr == ADDR_W'(NUM_FIELDS + 1));

  cra_regs #(.FIELD_W(FIELD_W), .NUM_FIELDS(NUM_FIELDS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .flag(alarm_flag), .ctrl(ctrl), .tgt_val(tgt_val),
    .rpt(rpt), .rdata(rdata)
  );

  cra_match #(.FIELD_W(FIELD_W), .NUM_FIELDS(NUM_FIELDS)) u_match (
    .tgt_val(tgt_val), .rpt(rpt), .cur_time(cur_time), .hit(hit)
  );

  cra_flag u_flag (
    .clk(clk), .rst(rst), .sec_tick(sec_tick),
    .alarm_en(ctrl[cra_pkg::CTRL_EN_BIT]), .hit(hit), .clr_req(clr_req),
    .irq_en(ctrl[cra_pkg::CTRL_IRQ_BIT]), .bkup_en(ctrl[cra_pkg::CTRL_BKUP_BIT]),
    .on_backup(on_backup), .flag(alarm_flag), .irq(irq)
  );
endmodule

// File: rtl/cra_checker.sv
module cra_checker (
  input logic clk,
  input logic rst,
  input logic sec_tick,
  input logic alarm_en,
  input logic hit,
  input logic clr_req,
  input logic flag,
  input logic irq
);
  assert_reset_clear_R1: assert property (@(posedge clk) rst |=> (!flag && !irq));
  assert_disabled_no_set_R2: assert property (@(posedge clk) disable iff (rst)
    (!alarm_en && !flag) |=> !flag);
  assert_match_sets_R3: assert property (@(posedge clk) disable iff (rst)
    (sec_tick && alarm_en && hit) |=> flag);
  assert_no_tick_stable_R4: assert property (@(posedge clk) disable iff (rst)
    (!sec_tick && !clr_req) |=> $stable(flag));
  assert_read_clears_R7: assert property (@(posedge clk) disable iff (rst)
    (clr_req && !(sec_tick && alarm_en && hit)) |=> !flag);
  assert_match_wins_R8: assert property (@(posedge clk) disable iff (rst)
    (clr_req && sec_tick && alarm_en && hit) |=> flag);
  assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (rst)
    irq |-> flag);
endmodule

bind cal_repeat_alarm cra_checker u_chk (
  .clk(clk), .rst(rst), .sec_tick(sec_tick), .alarm_en(ctrl[0]), .hit(hit),
  .clr_req(clr_req), .flag(alarm_flag), .irq(irq)
);

// File: tb/tb_cal_repeat_alarm.sv
module tb_cal_repeat_alarm;
  localparam int FW = 7;
  localparam int NF = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [NF*FW-1:0] cur_time = '0;
  logic sec_tick = 1'b0;
  logic on_backup = 1'b0;
  logic irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cal_repeat_alarm dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .cur_time(cur_time), .sec_tick(sec_tick),
    .on_backup(on_backup), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; addr = 3'(a); wdata = 8'(d);
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    rd_en = 1'b1; addr = 3'(a);
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
    d = int'(rdata);
  endtask

  function automatic logic [NF*FW-1:0] tval(input int bump);
    logic [NF*FW-1:0] t;
    for (int i = 0; i < NF; i++) t[i*FW +: FW] = FW'(10 + i + ((bump >> i) & 1));
    return t;
  endfunction

  task automatic tick(input logic [NF*FW-1:0] t);
    @(negedge clk);
    cur_time = t; sec_tick = 1'b1;
    @(posedge clk);
    @(negedge clk);
    sec_tick = 1'b0;
  endtask

  task automatic set_targets(input int rptmask);
    for (int i = 0; i < NF; i++) wr(i + 1, (((rptmask >> i) & 1) << 7) | (10 + i));
  endtask

  task automatic t_reset;
    int d;
    chk("R1 irq", int'(irq), 0);
    rd(0, d); chk("R1 ctrl", d, 0);
    rd(3, d); chk("R1 byte", d, 0);
    rd(6, d); chk("R1 flag", d, 0);
    rd(7, d); chk("R10 addr7", d, 0);
  endtask

  task automatic t_storage;
    int d;
    wr(0, 8'h02);
    for (int i = 0; i < NF; i++) wr(i + 1, 8'hA5 ^ (i * 17));
    for (int i = 0; i < NF; i++) begin
      rd(i + 1, d); chk("R2 readback", d, (8'hA5 ^ (i * 17)) & 8'hFF);
    end
    wr(1, 8'hFF);
    tick('0); tick({NF*FW{1'b1}});
    chk("R2 irq", int'(irq), 0);
    rd(6, d); chk("R2 no flag", d, 0);
    rd(0, d); chk("R10 ctrl", d, 2);
  endtask

  // k = number of fields compared, from seconds upward
  task automatic t_mode(input int k);
    int d;
    set_targets(((1 << NF) - 1) & ~((1 << k) - 1));
    wr(0, 8'h03);
    tick(tval(((1 << NF) - 1) & ~((1 << k) - 1)));
    chk("R5 irq on match", int'(irq), 1);
    rd(6, d); chk("R5 flag on match", d, 1);
    chk("R7 irq cleared", int'(irq), 0);
    rd(6, d); chk("R7 flag cleared", d, 0);
    if (k > 0) begin
      tick(tval(1 << (k - 1)));
      rd(6, d); chk("R5 compared field mismatch", d, 0);
    end
  endtask

  task automatic t_odd_code;
    int d;
    set_targets(5'b10100);
    wr(0, 8'h01);
    tick(tval(5'b11100));
    rd(6, d); chk("R6 odd code masks upward", d, 1);
    tick(tval(5'b00010));
    rd(6, d); chk("R6 minutes still compared", d, 0);
  endtask

  task automatic t_no_tick;
    int d;
    set_targets(0);
    wr(0, 8'h03);
    @(negedge clk); cur_time = tval(0);
    repeat (3) @(negedge clk);
    chk("R4 no tick irq", int'(irq), 0);
    rd(6, d); chk("R4 no tick flag", d, 0);
    tick(tval(0));
    chk("R3 sticky", int'(irq), 1);
    tick(tval(1));
    chk("R3 sticky after mismatch", int'(irq), 1);
    rd(6, d); chk("R3 flag read", d, 1);
  endtask

  task automatic t_collide;
    int d;
    set_targets(5'b11111);
    wr(0, 8'h01);
    @(negedge clk);
    rd_en = 1'b1; addr = 3'd6; cur_time = '0; sec_tick = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0; sec_tick = 1'b0;
    chk("R8 read value before set", int'(rdata), 0);
    rd(6, d); chk("R8 match wins", d, 1);
  endtask

  task automatic t_irq_gate;
    int d;
    set_targets(5'b11111);
    wr(0, 8'h01);
    tick('0);
    chk("R9 irq off when disabled", int'(irq), 0);
    rd(6, d); chk("R9 flag still set", d, 1);
    wr(0, 8'h03);
    @(negedge clk); on_backup = 1'b1;
    tick('0);
    chk("R9 backup blocks irq", int'(irq), 0);
    wr(0, 8'h07);
    tick('0);
    chk("R9 backup enable allows irq", int'(irq), 1);
    rd(6, d);
    chk("R9 irq clears with flag", int'(irq), 0);
    on_backup = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_storage();
    for (int k = 0; k <= NF; k++) t_mode(k);
    t_odd_code();
    t_no_tick();
    t_collide();
    t_irq_gate();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule